// File: doc/BRIEF.md
# Two-Phase Interleaved Current-Balanced PWM

This block drives two power stages from one switching period. A free-running counter supplies a sawtooth for the first channel. The second channel uses the same sawtooth shifted by half a period, so its pulses sit midway between the first channel's pulses. A digital error word sets the requested on-time in counter ticks. Each channel trims that request by its own current-balance correction. The result is clamped into the period, and the channel drives its output high while its sawtooth is below the trimmed value.

Each phase reports its current as a digital word on a level input. There is no handshake and no back-pressure on these inputs. The block reads each word only at its phase's sampling instant, which falls one third of a period into the low-side interval. From the two held samples it forms the average, which it exports as a droop term. Each phase is corrected by the average minus its own sample. The block also raises an overcurrent flag when the average passes a trip level. A per-channel mode word can force an output low or release it to high impedance. Release is signalled through a separate output-enable pin.

Top module: `pwm2_ctrl`

## Requirements
- R1: Both channels repeat every PERIOD clocks (default 60). The second channel's pulse starts exactly PERIOD/2 clocks after the first channel's pulse starts.
- R2: In normal mode, a channel is high for exactly D consecutive clocks at the start of each of its periods. D is its clamped duty. With equal phase currents, D equals the error word, so a larger error word gives a longer pulse.
- R3: The duty is err + correction, clamped to the range 0 to PERIOD-1. A negative sum gives no pulse. A sum of PERIOD-1 or more gives PERIOD-1 high clocks, followed by one low clock.
- R4: A change of the error word in the middle of a period does not alter the pulse already under way. It takes effect at that channel's next period start.
- R5: A phase's current word is captured on the clock edge where that channel's sawtooth equals D + PERIOD/3. If that sum is PERIOD or more, capture instead happens where the sawtooth equals PERIOD-1. Values present at any other time are ignored.
- R6: droop_o equals floor((sample0 + sample1) / 2) of the two held samples.
- R7: Each channel's correction is (average − own sample), arithmetically shifted right by CORR_SHIFT (default 0). A phase above the average gets a shorter pulse, and a phase below it gets a longer one.
- R8: ocp_o is high one clock after the average becomes strictly greater than TRIP (default 75). It is low one clock after the average becomes less than or equal to TRIP. The flag does not latch.
- R9: The mode code for each channel is 2'b00 normal, 2'b01 forced low (enable 1, level 0), and 2'b10 or 2'b11 high impedance (enable 0, level 0). A new mode shows at the outputs after the next clock edge.
- R10: While rst_n is low, pwm_o and pwm_oe_o are 0, droop_o is 0 and ocp_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_i | input | ERR_W | Requested on-time in clock ticks |
| isense_i | input | 2×CUR_W | Per-phase current words, index 0 and 1 |
| mode_i | input | 2×2 | Per-channel output mode code |
| pwm_o | output | 2 | PWM level per channel |
| pwm_oe_o | output | 2 | Output enable per channel (0 = high impedance) |
| droop_o | output | CUR_W | Average of the two held current samples |
| ocp_o | output | 1 | Average above trip level |

## Verification
The bench changes the current word during the low-side interval, both just before and exactly at the capture clock. A design that samples one clock off, or that tracks the input continuously, shows a droop value that moves early or misses the change. The same capture test is repeated with a duty long enough that the one-third point would fall past the period end. A design without the end-of-period fallback would then never capture, or would capture in the next period. The error word is changed just after a pulse starts, so a design that reloads the duty mid-period gives a truncated or stretched pulse. The trip compare is probed at exactly 75 and 76, which catches a greater-or-equal comparison. Clamping is driven from both sides, where a wrapped sum would give a near-full pulse instead of none.

// File: rtl/pwm2_pkg.sv
`timescale 1ns/1ps
package pwm2_pkg;
  localparam int NPH = 2;

  typedef enum logic [1:0] {
    OUT_NORMAL  = 2'b00,
    OUT_LOW     = 2'b01,
    OUT_HIZ     = 2'b10,
    OUT_HIZ_ALT = 2'b11
  } out_mode_e;

  // true when the channel's driver stays enabled
  function automatic logic mode_drives(input logic [1:0] m);
    return (m == OUT_NORMAL) || (m == OUT_LOW);
  endfunction
endpackage

// File: rtl/pwm2_timebase.sv
`timescale 1ns/1ps
module pwm2_timebase #(
  parameter int PERIOD = 60,
  localparam int CW    = $clog2(PERIOD),
  localparam int HALF  = PERIOD / 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  output logic [pwm2_pkg::NPH-1:0][CW-1:0] saw_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (cnt == CW'(PERIOD - 1))   cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

  // channel 0 sees the raw count, channel 1 the count moved by half a period
  for (genvar k = 0; k < pwm2_pkg::NPH; k++) begin : g_saw
    if (k == 0) begin : g_lead
      assign saw_o[k] = cnt;
    end else begin : g_lag
      assign saw_o[k] = (cnt >= CW'(HALF)) ? cnt - CW'(HALF) : cnt + CW'(HALF);
    end
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(PERIOD - 1)) |=> (cnt == '0));
  p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (saw_o[0] == '0) |-> (saw_o[1] == CW'(HALF)));
endmodule

// File: rtl/pwm2_balance.sv
`timescale 1ns/1ps
module pwm2_balance #(
  parameter int CUR_W      = 8,
  parameter int TRIP       = 75,
  parameter int CORR_SHIFT = 0
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic [pwm2_pkg::NPH-1:0][CUR_W-1:0]          isense_i,
  input  logic [pwm2_pkg::NPH-1:0]                     strobe_i,
  output logic signed [CUR_W:0]                        corr0_o,
  output logic signed [CUR_W:0]                        corr1_o,
  output logic [CUR_W-1:0]                             droop_o,
  output logic                                         ocp_o
);
  logic [pwm2_pkg::NPH-1:0][CUR_W-1:0] held_q;
  logic [CUR_W:0]                      pair_sum;
  logic [CUR_W-1:0]                    avg;
  logic signed [CUR_W:0]               diff0, diff1;
  logic                                ocp_q;
  logic                                over_trip;

  for (genvar k = 0; k < pwm2_pkg::NPH; k++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          held_q[k] <= '0;
      else if (strobe_i[k]) held_q[k] <= isense_i[k];
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_i[k] |=> $stable(held_q[k]));
  end

  assign pair_sum  = {1'b0, held_q[0]} + {1'b0, held_q[1]};
  assign avg       = pair_sum[CUR_W:1];
  assign over_trip = ({1'b0, avg} > (CUR_W+1)'(TRIP));

  assign diff0   = $signed({1'b0, avg}) - $signed({1'b0, held_q[0]});
  assign diff1   = $signed({1'b0, avg}) - $signed({1'b0, held_q[1]});
  assign corr0_o = diff0 >>> CORR_SHIFT;
  assign corr1_o = diff1 >>> CORR_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ocp_q <= 1'b0;
    else        ocp_q <= over_trip;
  end

  assign droop_o = avg;
  assign ocp_o   = ocp_q;

  p_ocp_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    over_trip |=> ocp_o);
  p_ocp_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !over_trip |=> !ocp_o);
  p_corr_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q[0] > held_q[1]) |-> (corr0_o <= 0) && (corr1_o >= 0));
endmodule

// File: rtl/pwm2_phase.sv
`timescale 1ns/1ps
module pwm2_phase #(
  parameter int PERIOD = 60,
  parameter int ERR_W  = 8,
  parameter int CUR_W  = 8,
  localparam int CW    = $clog2(PERIOD),
  localparam int THIRD = PERIOD / 3,
  localparam int MW    = (ERR_W > CUR_W) ? ((ERR_W > CW) ? ERR_W : CW)
                                         : ((CUR_W > CW) ? CUR_W : CW),
  localparam int SW    = MW + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         saw_i,
  input  logic [ERR_W-1:0]      err_i,
  input  logic signed [CUR_W:0] corr_i,
  input  logic [1:0]            mode_i,
  output logic                  strobe_o,
  output logic                  pwm_o,
  output logic                  oe_o
);
  import pwm2_pkg::*;

  localparam logic signed [SW-1:0] LIM = SW'(PERIOD - 1);

  logic signed [SW-1:0] err_s, corr_s, sum;
  logic [CW-1:0]        duty_new, duty_q, duty_eff;
  logic [CW:0]          thresh;
  logic                 lvl_q, oe_q;

  assign err_s  = $signed(SW'(err_i));
  assign corr_s = SW'(corr_i);
  assign sum    = err_s + corr_s;

  always_comb begin
    if (sum[SW-1])     duty_new = '0;
    else if (sum > LIM) duty_new = CW'(PERIOD - 1);
    else               duty_new = sum[CW-1:0];
  end

  // the new duty is used from the period's first tick and held to its end
  assign duty_eff = (saw_i == '0) ? duty_new : duty_q;

  assign thresh   = {1'b0, duty_q} + (CW+1)'(THIRD);
  assign strobe_o = (thresh < (CW+1)'(PERIOD)) ? (saw_i == thresh[CW-1:0])
                                               : (saw_i == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      lvl_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (saw_i == '0) duty_q <= duty_new;
      lvl_q <= (mode_i == OUT_NORMAL) && (duty_eff > saw_i);
      oe_q  <= mode_drives(mode_i);
    end
  end

  assign pwm_o = lvl_q;
  assign oe_o  = oe_q;

  p_hold_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (saw_i != '0) |=> $stable(duty_q));
  p_duty_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q <= CW'(PERIOD - 1));
  p_end_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (saw_i == CW'(PERIOD - 1)) |=> !pwm_o);
  p_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_drives(mode_i) |=> (!oe_o && !pwm_o));
  p_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OUT_LOW) |=> (oe_o && !pwm_o));
endmodule

// File: rtl/pwm2_ctrl.sv
`timescale 1ns/1ps
module pwm2_ctrl #(
  parameter int PERIOD     = 60,
  parameter int ERR_W      = 8,
  parameter int CUR_W      = 8,
  parameter int TRIP       = 75,
  parameter int CORR_SHIFT = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ERR_W-1:0]       err_i,
  input  logic [1:0][CUR_W-1:0]  isense_i,
  input  logic [1:0][1:0]        mode_i,
  output logic [1:0]             pwm_o,
  output logic [1:0]             pwm_oe_o,
  output logic [CUR_W-1:0]       droop_o,
  output logic                   ocp_o
);
  localparam int CW = $clog2(PERIOD);
  localparam int NP = pwm2_pkg::NPH;

  logic [NP-1:0][CW-1:0]    saw;
  logic [NP-1:0]            strobe;
  logic signed [CUR_W:0]    corr [NP];

  pwm2_timebase #(.PERIOD(PERIOD)) u_tb (
    .clk   (clk),
    .rst_n (rst_n),
    .saw_o (saw)
  );

  pwm2_balance #(.CUR_W(CUR_W), .TRIP(TRIP), .CORR_SHIFT(CORR_SHIFT)) u_bal (
    .clk      (clk),
    .rst_n    (rst_n),
    .isense_i (isense_i),
    .strobe_i (strobe),
    .corr0_o  (corr[0]),
    .corr1_o  (corr[1]),
    .droop_o  (droop_o),
    .ocp_o    (ocp_o)
  );

  for (genvar k = 0; k < NP; k++) begin : g_ph
    pwm2_phase #(.PERIOD(PERIOD), .ERR_W(ERR_W), .CUR_W(CUR_W)) u_ph (
      .clk      (clk),
      .rst_n    (rst_n),
      .saw_i    (saw[k]),
      .err_i    (err_i),
      .corr_i   (corr[k]),
      .mode_i   (mode_i[k]),
      .strobe_o (strobe[k]),
      .pwm_o    (pwm_o[k]),
      .oe_o     (pwm_oe_o[k])
    );
  end
endmodule

// File: tb/tb_pwm2_ctrl.sv
`timescale 1ns/1ps
module tb_pwm2_ctrl;
  localparam int P = 60, HALF = 30, THIRD = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [7:0]       err = 8'd20;
  logic [1:0][7:0]  isense = {8'd40, 8'd40};
  logic [1:0][1:0]  mode = '0;
  logic [1:0]       pwm, oe;
  logic [7:0]       droop;
  logic             ocp;
  int               n_chk = 0, n_fail = 0;

  pwm2_ctrl dut (
    .clk(clk), .rst_n(rst_n), .err_i(err), .isense_i(isense), .mode_i(mode),
    .pwm_o(pwm), .pwm_oe_o(oe), .droop_o(droop), .ocp_o(ocp)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input int e, input int c0, input int c1);
    err = 8'(e); isense[0] = 8'(c0); isense[1] = 8'(c1);
    cyc(3 * P);
  endtask

  task automatic high_count(input int ch, output int hi);
    hi = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (pwm[ch]) hi++;
    end
  endtask

  task automatic wait_edge(input int ch, input bit rise);
    bit prev;
    prev = pwm[ch];
    for (int i = 0; i < 3 * P; i++) begin
      @(negedge clk);
      if (pwm[ch] == rise && prev != rise) break;
      prev = pwm[ch];
    end
  endtask

  task automatic t_reset();
    cyc(3);
    chk(pwm == 2'b00 && oe == 2'b00, "R10 outputs in reset", {pwm, oe}, 0);
    chk(droop == 0 && ocp == 0, "R10 droop/ocp in reset", {droop, ocp}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_interleave();
    int k, to1;
    bit p0, p1;
    setup(20, 40, 40);
    wait_edge(0, 1);
    k = 0; to1 = -1; p0 = pwm[0]; p1 = pwm[1];
    for (int i = 0; i < 2 * P; i++) begin
      @(negedge clk); k++;
      if (to1 < 0 && pwm[1] && !p1) to1 = k;
      if (pwm[0] && !p0) break;
      p0 = pwm[0]; p1 = pwm[1];
    end
    chk(to1 == HALF, "R1 channel 1 start offset", to1, HALF);
    chk(k == P, "R1 period length", k, P);
  endtask

  task automatic t_duty();
    int h0, h1;
    setup(10, 40, 40);
    high_count(0, h0); chk(h0 == 10, "R2 ch0 duty err=10", h0, 10);
    high_count(1, h1); chk(h1 == 10, "R2 ch1 duty err=10", h1, 10);
    setup(40, 40, 40);
    high_count(0, h0); chk(h0 == 40, "R2 ch0 duty err=40", h0, 40);
    chk(oe == 2'b11, "R9 normal mode enabled", oe, 3);
  endtask

  task automatic t_clamp();
    int h0, h1;
    setup(255, 40, 40);
    high_count(0, h0); chk(h0 == P - 1, "R3 upper clamp ch0", h0, P - 1);
    high_count(1, h1); chk(h1 == P - 1, "R3 upper clamp ch1", h1, P - 1);
    setup(0, 40, 40);
    high_count(0, h0); chk(h0 == 0, "R3 zero duty", h0, 0);
    setup(5, 60, 40);
    high_count(0, h0); chk(h0 == 0, "R3 negative sum clamps to 0", h0, 0);
    high_count(1, h1); chk(h1 == 15, "R7 ch1 raised with clamp", h1, 15);
  endtask

  task automatic t_balance();
    int h0, h1;
    setup(20, 60, 40);
    high_count(0, h0); chk(h0 == 10, "R7 ch0 above avg shortened", h0, 10);
    high_count(1, h1); chk(h1 == 30, "R7 ch1 below avg lengthened", h1, 30);
    chk(droop == 50, "R6 droop average", droop, 50);
    setup(20, 13, 10);
    chk(droop == 11, "R6 droop floor", droop, 11);
  endtask

  task automatic t_boundary();
    int run;
    setup(20, 40, 40);
    wait_edge(0, 1);
    err = 8'd45;
    run = 1;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (!pwm[0]) break;
      run++;
    end
    chk(run == 20, "R4 pulse in flight unchanged", run, 20);
    wait_edge(0, 1);
    run = 1;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (!pwm[0]) break;
      run++;
    end
    chk(run == 45, "R4 new duty next period", run, 45);
  endtask

  task automatic sample_probe(input int e, input int off, input string tag);
    setup(e, 40, 40);
    wait_edge(0, 0);
    isense[0] = 8'd200;
    cyc(off - 1);
    chk(droop == 40, {tag, " value before capture ignored"}, droop, 40);
    isense[0] = 8'd80;
    cyc(1);
    chk(droop == 60, {tag, " captured at sample point"}, droop, 60);
    isense[0] = 8'd40;
  endtask

  task automatic t_ocp();
    setup(20, 80, 80);  chk(ocp == 1, "R8 avg 80 trips", ocp, 1);
    setup(20, 75, 75);  chk(ocp == 0, "R8 avg 75 no trip", ocp, 0);
    setup(20, 76, 76);  chk(ocp == 1, "R8 avg 76 trips", ocp, 1);
    setup(20, 100, 50); chk(ocp == 0, "R8 avg 75 mixed no trip", ocp, 0);
    chk(droop == 75, "R6 droop mixed", droop, 75);
    setup(20, 40, 40);  chk(ocp == 0, "R8 flag clears", ocp, 0);
  endtask

  task automatic t_mode();
    int hi, en, h1;
    setup(20, 40, 40);
    mode[0] = 2'b01;
    cyc(1);
    chk(oe[0] == 1 && pwm[0] == 0, "R9 forced low next clock", {oe[0], pwm[0]}, 2);
    hi = 0; en = 0;
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      if (pwm[0]) hi++;
      if (oe[0]) en++;
    end
    chk(hi == 0 && en == P, "R9 forced low whole period", hi, 0);
    high_count(1, h1); chk(h1 == 20, "R9 other channel unaffected", h1, 20);
    mode[1] = 2'b10;
    cyc(1);
    chk(oe[1] == 0 && pwm[1] == 0, "R9 high-Z code 10", {oe[1], pwm[1]}, 0);
    mode[1] = 2'b11;
    cyc(P);
    chk(oe[1] == 0 && pwm[1] == 0, "R9 high-Z code 11", {oe[1], pwm[1]}, 0);
    mode = '0;
    cyc(1);
    chk(oe == 2'b11, "R9 back to normal", oe, 3);
    high_count(0, hi); chk(hi == 20, "R9 normal duty restored", hi, 20);
  endtask

  initial begin
    #(64'd2000000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_interleave();
    t_duty();
    t_clamp();
    t_balance();
    t_boundary();
    sample_probe(20, THIRD, "R5 third into low side");
    sample_probe(55, 4, "R5 short low side end of period");
    t_ocp();
    t_mode();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule